// File: doc/BRIEF.md
# Descriptor Ring Controller

This block keeps the transmit and receive buffer descriptors for a network port in a small on-chip table. A host fills and inspects the table through a word-wide read/write port. Two ring walkers run at the same time, one for each direction. A walker finds the next descriptor that hardware owns. It hands that descriptor's buffer pointer, length and option bits to the MAC side through a start handshake. It then waits for a done handshake carrying the completion status.

When a job completes, the walker writes the status back and gives ownership back to the host in a single table update. It raises a sticky per-ring interrupt flag if the descriptor asked for one. It then moves to the next entry, or back to the start of its ring. One host register sets how many descriptors the transmit ring uses. The receive ring takes the remaining entries, starting right after the transmit ring. A soft-reset command sends both walkers back to their ring starts.

Each descriptor is two words: a status/control word at an even word address, then the buffer pointer at the next odd address. Status word fields:

| Bits | Meaning |
|---|---|
| 31:16 | Length in bytes |
| 15 | Hardware owns the entry |
| 14 | Interrupt on completion |
| 13 | Wrap to ring start after this entry |
| 12 | Pad request (transmit only) |
| 11 | CRC request (transmit only) |
| 7:0 | Completion status |

Top module: `bdring_ctrl`

## Requirements
- R1: Host word address 2i holds the status word of descriptor i and address 2i+1 holds its pointer. Address bit 4 set (default build) selects the register space instead. A host read returns the addressed word on `host_rdata` one clock after the `host_rd` cycle.
- R2: When a walker reaches an entry whose status bit 15 is set, it raises its start valid. The offer carries the pointer word and length = status[31:16]. On the transmit side it also carries pad = bit 12 and CRC = bit 11. The offer is held unchanged until start ready is seen.
- R3: An entry with bit 15 clear stalls its walker on that entry. There is no offer and no move to later entries. The offer appears once the host sets bit 15.
- R4: On the done handshake, the entry's status word is rewritten in one update. Bit 15 becomes 0, bits 14:8 keep their value and bits 7:0 take the done status. Transmit keeps bits 31:16. Receive writes the done length into bits 31:16.
- R5: After a completion the walker goes to the next index. It returns to its ring start instead if the entry had wrap (bit 13) set or was the last entry of its ring.
- R6: Register 0 (the split) holds the transmit descriptor count. Writes above the table size are clamped to the table size. The transmit ring is entries 0 to split-1. The receive ring is entries split to the table size minus 1. A ring with no entries never offers.
- R7: A completion of an entry with bit 14 set sets that ring's interrupt flag. Flags are read in register 2: bit 0 is transmit and bit 1 is receive. Each flag stays set until the host writes 1 to its bit. Completions without bit 14 leave the flags unchanged.
- R8: Writing 1 to bit 0 of register 1 returns both walkers to their ring starts, using the split value from before that write.
- R9: After reset the table is all zero, the split is half the table size, both interrupts are low and no offer is raised.
- R10: Start valid drops in the cycle after it is accepted. Done ready is high exactly while an accepted job awaits completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 5 | Host word address; MSB selects registers |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the read |
| tx_start_valid | output | 1 | Transmit job offered |
| tx_start_ready | input | 1 | MAC accepts transmit job |
| tx_start_ptr | output | 32 | Transmit buffer pointer |
| tx_start_len | output | 16 | Transmit byte count |
| tx_start_pad | output | 1 | Pad short frame request |
| tx_start_crc | output | 1 | Append CRC request |
| tx_done_valid | input | 1 | Transmit job finished |
| tx_done_ready | output | 1 | Transmit walker awaits completion |
| tx_done_stat | input | 8 | Transmit completion status |
| rx_start_valid | output | 1 | Receive buffer offered |
| rx_start_ready | input | 1 | MAC accepts receive buffer |
| rx_start_ptr | output | 32 | Receive buffer pointer |
| rx_start_len | output | 16 | Receive buffer capacity |
| rx_done_valid | input | 1 | Receive job finished |
| rx_done_ready | output | 1 | Receive walker awaits completion |
| rx_done_stat | input | 8 | Receive completion status |
| rx_done_len | input | 16 | Received byte count |
| irq_tx | output | 1 | Sticky transmit interrupt flag |
| irq_rx | output | 1 | Sticky receive interrupt flag |

## Verification
The properties assume that the MAC side treats each start offer as a request it may take at any time. They also assume done valid is only raised while done ready is high. The offer-holding properties therefore exclude the cycle of a soft reset, which legitimately withdraws an offer. The bench's MAC model pulses start ready and done valid for one cycle each, only after observing the matching valid or ready. The host changes the split only together with a soft reset, so the walkers never sit outside their own rings. A small eight-entry table is swept word by word, and each ring is walked through its wrap, end-of-ring, stall and split cases.

// File: rtl/bdring_pkg.sv
// Package: shared field positions, register selectors and walker states
// for the descriptor ring controller. Assumes 32-bit table words.
package bdring_pkg;
    localparam int BD_OWN  = 15;
    localparam int BD_IRQ  = 14;
    localparam int BD_WRAP = 13;
    localparam int BD_PAD  = 12;
    localparam int BD_CRC  = 11;
    localparam int LEN_LSB = 16;
    localparam int WORD_W  = 32;
    localparam int LEN_W   = 16;

    localparam int REG_SPLIT = 0;
    localparam int REG_CTRL  = 1;
    localparam int REG_IRQ   = 2;

    typedef enum logic [1:0] {
        WK_SCAN  = 2'd0,
        WK_OFFER = 2'd1,
        WK_BUSY  = 2'd2
    } wk_state_e;
endpackage

// File: rtl/bdring_table.sv
// Module: descriptor table. Flop array of two words per descriptor with
// one host write/read port and one status write plus status/pointer read
// port per walker. Assumes walkers only write their own current entry;
// on a same-word collision a walker write wins over the host.
module bdring_table
    import bdring_pkg::*;
#(
    parameter int NUM_BD = 8,
    parameter int NUM_WK = 2,
    localparam int IDX_W = $clog2(NUM_BD),
    localparam int WA_W  = IDX_W + 1,
    localparam int WORDS = 2 * NUM_BD
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_we,
    input  logic [WA_W-1:0]                host_wa,
    input  logic [WORD_W-1:0]              host_wdata,
    output logic [WORD_W-1:0]              host_rword,
    input  logic [NUM_WK-1:0][IDX_W-1:0]   wk_idx,
    output logic [NUM_WK-1:0][WORD_W-1:0]  wk_stat,
    output logic [NUM_WK-1:0][WORD_W-1:0]  wk_ptr,
    input  logic [NUM_WK-1:0]              wk_we,
    input  logic [NUM_WK-1:0][WORD_W-1:0]  wk_wword
);
    logic [WORD_W-1:0] mem [WORDS];

    // Table update: host first, walker status writes take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else begin
            if (host_we) mem[host_wa] <= host_wdata;
            for (int k = 0; k < NUM_WK; k++) begin
                if (wk_we[k]) mem[{wk_idx[k], 1'b0}] <= wk_wword[k];
            end
        end
    end

    // Host read word, registered in the register block.
    assign host_rword = mem[host_wa];

    // Per-walker read of the current descriptor.
    for (genvar k = 0; k < NUM_WK; k++) begin : g_rd
        assign wk_stat[k] = mem[{wk_idx[k], 1'b0}];
        assign wk_ptr[k]  = mem[{wk_idx[k], 1'b1}];
    end
endmodule

// File: rtl/bdring_walker.sv
// Module: one ring walker. Scans its current entry, captures it when owned,
// offers it to the MAC, waits for completion, writes status back and steps
// on (next, or ring start after wrap or the last ring entry).
// Assumes ring_first/ring_cnt only change together with srst.
module bdring_walker
    import bdring_pkg::*;
#(
    parameter int NUM_BD = 8,
    parameter int STAT_W = 8,
    parameter bit IS_RX  = 1'b0,
    localparam int IDX_W = $clog2(NUM_BD),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic [IDX_W-1:0]  ring_first,
    input  logic [CNT_W-1:0]  ring_cnt,
    output logic [IDX_W-1:0]  cur_idx,
    input  logic [WORD_W-1:0] stat_word,
    input  logic [WORD_W-1:0] ptr_word,
    output logic              start_valid,
    input  logic              start_ready,
    output logic [WORD_W-1:0] start_ptr,
    output logic [LEN_W-1:0]  start_len,
    output logic [1:0]        start_opt,
    input  logic              done_valid,
    output logic              done_ready,
    input  logic [STAT_W-1:0] done_stat,
    input  logic [LEN_W-1:0]  done_len,
    output logic              wb_en,
    output logic [WORD_W-1:0] wb_word,
    output logic              irq_pulse
);
    wk_state_e         state;
    logic [LEN_W-1:0]  cap_len;
    logic [3:0]        cap_ctl;   // {irq, wrap, pad, crc}
    logic              ring_on;
    logic [CNT_W-1:0]  ring_last;
    logic              at_end;
    logic [IDX_W-1:0]  nxt_idx;

    // Ring geometry and next-index choice.
    assign ring_on   = (ring_cnt != '0);
    assign ring_last = {1'b0, ring_first} + ring_cnt - CNT_W'(1);
    assign at_end    = ({1'b0, cur_idx} == ring_last);
    assign nxt_idx   = (cap_ctl[2] || at_end) ? ring_first : cur_idx + IDX_W'(1);

    // Walker sequencing: scan, offer, wait for completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WK_SCAN;
            cur_idx   <= ring_first;
            start_ptr <= '0;
            cap_len   <= '0;
            cap_ctl   <= '0;
        end else if (srst) begin
            state   <= WK_SCAN;
            cur_idx <= ring_first;
        end else begin
            case (state)
                WK_SCAN: begin
                    if (ring_on && stat_word[BD_OWN]) begin
                        start_ptr <= ptr_word;
                        cap_len   <= stat_word[LEN_LSB +: LEN_W];
                        cap_ctl   <= stat_word[BD_CRC +: 4];
                        state     <= WK_OFFER;
                    end
                end
                WK_OFFER: begin
                    if (start_ready) state <= WK_BUSY;
                end
                WK_BUSY: begin
                    if (done_valid) begin
                        cur_idx <= nxt_idx;
                        state   <= WK_SCAN;
                    end
                end
                default: state <= WK_SCAN;
            endcase
        end
    end

    // MAC-side handshake outputs.
    assign start_valid = (state == WK_OFFER);
    assign start_len   = cap_len;
    assign start_opt   = cap_ctl[1:0];
    assign done_ready  = (state == WK_BUSY);

    // Completion: status write-back word, releasing ownership.
    always_comb begin
        wb_word                    = stat_word;
        wb_word[LEN_LSB +: LEN_W]  = IS_RX ? done_len : cap_len;
        wb_word[BD_OWN]            = 1'b0;
        wb_word[BD_CRC +: 4]       = cap_ctl;
        wb_word[STAT_W-1:0]        = done_stat;
    end
    assign wb_en     = done_ready && done_valid;
    assign irq_pulse = wb_en && cap_ctl[3];
endmodule

// File: rtl/bdring_regs.sv
// Module: host register space and read path. Holds the ring split, emits
// the soft-reset pulse, keeps sticky interrupt flags, registers read data.
// Assumes one host access per cycle.
module bdring_regs
    import bdring_pkg::*;
#(
    parameter int NUM_BD = 8,
    localparam int IDX_W = $clog2(NUM_BD),
    localparam int CNT_W = IDX_W + 1,
    localparam int HA_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [WORD_W-1:0] mem_rword,
    input  logic [1:0]        irq_set,
    output logic              mem_we,
    output logic [CNT_W-1:0]  split,
    output logic              srst,
    output logic [1:0]        irq_flags,
    output logic [WORD_W-1:0] host_rdata
);
    logic              is_reg;
    logic [HA_W-2:0]   sel;
    logic [1:0]        irq_clr;
    logic [WORD_W-1:0] reg_rword;

    // Address decode.
    assign is_reg  = host_addr[HA_W-1];
    assign sel     = host_addr[HA_W-2:0];
    assign mem_we  = host_wr && !is_reg;
    assign srst    = host_wr && is_reg && (sel == (HA_W-1)'(REG_CTRL)) && host_wdata[0];
    assign irq_clr = (host_wr && is_reg && (sel == (HA_W-1)'(REG_IRQ))) ? host_wdata[1:0] : 2'b00;

    // Split register with clamp to the table size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split <= CNT_W'(NUM_BD / 2);
        end else if (host_wr && is_reg && (sel == (HA_W-1)'(REG_SPLIT))) begin
            if (host_wdata > WORD_W'(NUM_BD)) split <= CNT_W'(NUM_BD);
            else                             split <= host_wdata[CNT_W-1:0];
        end
    end

    // Sticky interrupt flags; a set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_flags <= 2'b00;
        else        irq_flags <= (irq_flags & ~irq_clr) | irq_set;
    end

    // Register read mux.
    always_comb begin
        reg_rword = '0;
        if (sel == (HA_W-1)'(REG_SPLIT))    reg_rword[CNT_W-1:0] = split;
        else if (sel == (HA_W-1)'(REG_IRQ)) reg_rword[1:0]       = irq_flags;
    end

    // Registered host read data.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= is_reg ? reg_rword : mem_rword;
    end
endmodule

// File: rtl/bdring_ctrl.sv
// Module: descriptor ring controller top. Shares one table between a
// transmit walker (entries 0..split-1) and a receive walker (entries
// split..NUM_BD-1). Assumes the MAC only completes accepted jobs.
module bdring_ctrl
    import bdring_pkg::*;
#(
    parameter int NUM_BD = 8,
    parameter int STAT_W = 8,
    localparam int IDX_W = $clog2(NUM_BD),
    localparam int CNT_W = IDX_W + 1,
    localparam int HA_W  = IDX_W + 2,
    localparam int NUM_WK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              tx_start_valid,
    input  logic              tx_start_ready,
    output logic [31:0]       tx_start_ptr,
    output logic [15:0]       tx_start_len,
    output logic              tx_start_pad,
    output logic              tx_start_crc,
    input  logic              tx_done_valid,
    output logic              tx_done_ready,
    input  logic [STAT_W-1:0] tx_done_stat,
    output logic              rx_start_valid,
    input  logic              rx_start_ready,
    output logic [31:0]       rx_start_ptr,
    output logic [15:0]       rx_start_len,
    input  logic              rx_done_valid,
    output logic              rx_done_ready,
    input  logic [STAT_W-1:0] rx_done_stat,
    input  logic [15:0]       rx_done_len,
    output logic              irq_tx,
    output logic              irq_rx
);
    logic                            mem_we;
    logic [WORD_W-1:0]               mem_rword;
    logic [CNT_W-1:0]                split;
    logic                            srst;
    logic [1:0]                      irq_flags;
    logic [NUM_WK-1:0][IDX_W-1:0]    wk_idx;
    logic [NUM_WK-1:0][WORD_W-1:0]   wk_stat;
    logic [NUM_WK-1:0][WORD_W-1:0]   wk_ptr;
    logic [NUM_WK-1:0]               wk_we;
    logic [NUM_WK-1:0][WORD_W-1:0]   wk_wword;
    logic [NUM_WK-1:0]               wk_irq;
    logic [NUM_WK-1:0][IDX_W-1:0]    ring_first;
    logic [NUM_WK-1:0][CNT_W-1:0]    ring_cnt;
    logic [NUM_WK-1:0]               wk_sv, wk_sr, wk_dv, wk_dr;
    logic [NUM_WK-1:0][WORD_W-1:0]   wk_sptr;
    logic [NUM_WK-1:0][LEN_W-1:0]    wk_slen;
    logic [NUM_WK-1:0][1:0]          wk_opt;
    logic [NUM_WK-1:0][STAT_W-1:0]   wk_dstat;
    logic [NUM_WK-1:0][LEN_W-1:0]    wk_dlen;
    logic [1:0]                      rx_opt_unused;

    // Ring geometry from the split register.
    assign ring_first[0] = '0;
    assign ring_cnt[0]   = split;
    assign ring_first[1] = split[IDX_W-1:0];
    assign ring_cnt[1]   = CNT_W'(NUM_BD) - split;

    // MAC-side inputs gathered per walker (0 = transmit, 1 = receive).
    assign wk_sr    = {rx_start_ready, tx_start_ready};
    assign wk_dv    = {rx_done_valid, tx_done_valid};
    assign wk_dstat = {rx_done_stat, tx_done_stat};
    assign wk_dlen  = {rx_done_len, LEN_W'(0)};

    bdring_regs #(.NUM_BD(NUM_BD)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .mem_rword  (mem_rword),
        .irq_set    (wk_irq),
        .mem_we     (mem_we),
        .split      (split),
        .srst       (srst),
        .irq_flags  (irq_flags),
        .host_rdata (host_rdata)
    );

    bdring_table #(.NUM_BD(NUM_BD), .NUM_WK(NUM_WK)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (mem_we),
        .host_wa    (host_addr[HA_W-2:0]),
        .host_wdata (host_wdata),
        .host_rword (mem_rword),
        .wk_idx     (wk_idx),
        .wk_stat    (wk_stat),
        .wk_ptr     (wk_ptr),
        .wk_we      (wk_we),
        .wk_wword   (wk_wword)
    );

    // One walker per direction; the receive one writes the received length.
    for (genvar g = 0; g < NUM_WK; g++) begin : g_wk
        bdring_walker #(
            .NUM_BD (NUM_BD),
            .STAT_W (STAT_W),
            .IS_RX  (g == 1)
        ) u_wk (
            .clk         (clk),
            .rst_n       (rst_n),
            .srst        (srst),
            .ring_first  (ring_first[g]),
            .ring_cnt    (ring_cnt[g]),
            .cur_idx     (wk_idx[g]),
            .stat_word   (wk_stat[g]),
            .ptr_word    (wk_ptr[g]),
            .start_valid (wk_sv[g]),
            .start_ready (wk_sr[g]),
            .start_ptr   (wk_sptr[g]),
            .start_len   (wk_slen[g]),
            .start_opt   (wk_opt[g]),
            .done_valid  (wk_dv[g]),
            .done_ready  (wk_dr[g]),
            .done_stat   (wk_dstat[g]),
            .done_len    (wk_dlen[g]),
            .wb_en       (wk_we[g]),
            .wb_word     (wk_wword[g]),
            .irq_pulse   (wk_irq[g])
        );
    end

    // Port mapping of walker outputs.
    assign tx_start_valid = wk_sv[0];
    assign tx_start_ptr   = wk_sptr[0];
    assign tx_start_len   = wk_slen[0];
    assign tx_start_pad   = wk_opt[0][1];
    assign tx_start_crc   = wk_opt[0][0];
    assign tx_done_ready  = wk_dr[0];
    assign rx_start_valid = wk_sv[1];
    assign rx_start_ptr   = wk_sptr[1];
    assign rx_start_len   = wk_slen[1];
    assign rx_done_ready  = wk_dr[1];
    assign rx_opt_unused  = wk_opt[1];
    assign irq_tx         = irq_flags[0];
    assign irq_rx         = irq_flags[1];
endmodule

// File: rtl/bdring_chk.sv
// Module: property checker for bdring_ctrl, attached by bind below.
// Assumes done valid is only driven while done ready is high.
module bdring_chk #(
    parameter int IDX_W = 3,
    parameter int CNT_W = 4,
    localparam int HA_W = IDX_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srst,
    input logic [HA_W-1:0]  host_addr,
    input logic             host_wr,
    input logic [31:0]      host_wdata,
    input logic             tx_sv,
    input logic             tx_sr,
    input logic [31:0]      tx_ptr,
    input logic [15:0]      tx_len,
    input logic             rx_sv,
    input logic             rx_sr,
    input logic [31:0]      rx_ptr,
    input logic [15:0]      rx_len,
    input logic [IDX_W-1:0] tx_idx,
    input logic [IDX_W-1:0] rx_idx,
    input logic [CNT_W-1:0] split,
    input logic [1:0]       wb_en,
    input logic [1:0]       wb_irq,
    input logic             irq_tx,
    input logic             irq_rx
);
    logic irq_wr;
    assign irq_wr = host_wr && host_addr[HA_W-1] && (host_addr[HA_W-2:0] == (HA_W-1)'(2));

    a_r2_tx_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sv && !tx_sr && !srst) |=> (tx_sv && $stable(tx_ptr) && $stable(tx_len)));
    a_r2_rx_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sv && !rx_sr && !srst) |=> (rx_sv && $stable(rx_ptr) && $stable(rx_len)));
    a_r10_tx_offer_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sv && tx_sr) |=> !tx_sv);
    a_r10_rx_offer_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sv && rx_sr) |=> !rx_sv);
    a_r8_srst_ring_start: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> ((tx_idx == '0) && (rx_idx == $past(split[IDX_W-1:0]))));
    a_r7_tx_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en[0] && wb_irq[0]) |=> irq_tx);
    a_r7_rx_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en[1] && wb_irq[1]) |=> irq_rx);
    a_r7_tx_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && !(irq_wr && host_wdata[0])) |=> irq_tx);
    a_r7_rx_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && !(irq_wr && host_wdata[1])) |=> irq_rx);
endmodule

bind bdring_ctrl bdring_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst       (srst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .tx_sv      (tx_start_valid),
    .tx_sr      (tx_start_ready),
    .tx_ptr     (tx_start_ptr),
    .tx_len     (tx_start_len),
    .rx_sv      (rx_start_valid),
    .rx_sr      (rx_start_ready),
    .rx_ptr     (rx_start_ptr),
    .rx_len     (rx_start_len),
    .tx_idx     (wk_idx[0]),
    .rx_idx     (wk_idx[1]),
    .split      (split),
    .wb_en      (wk_we),
    .wb_irq     (wk_irq),
    .irq_tx     (irq_tx),
    .irq_rx     (irq_rx)
);

// File: tb/sim_bdring_ctrl.sv
`timescale 1ns/1ps
module sim_bdring_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        tx_start_valid, tx_start_ready = 1'b0;
    logic [31:0] tx_start_ptr;
    logic [15:0] tx_start_len;
    logic        tx_start_pad, tx_start_crc;
    logic        tx_done_valid = 1'b0, tx_done_ready;
    logic [7:0]  tx_done_stat = '0;
    logic        rx_start_valid, rx_start_ready = 1'b0;
    logic [31:0] rx_start_ptr;
    logic [15:0] rx_start_len;
    logic        rx_done_valid = 1'b0, rx_done_ready;
    logic [7:0]  rx_done_stat = '0;
    logic [15:0] rx_done_len = '0;
    logic        irq_tx, irq_rx;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    bdring_ctrl u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [31:0] mk(input logic [15:0] len, input bit own, irq, wrap, pad, crc);
        return {len, own, irq, wrap, pad, crc, 11'b0};
    endfunction

    function automatic logic [4:0] sa(input int i); return 5'(2 * i); endfunction
    function automatic logic [4:0] pa(input int i); return 5'(2 * i + 1); endfunction

    task automatic arm(input int i, input logic [31:0] p, input logic [31:0] s);
        wr(pa(i), p);
        wr(sa(i), s);
    endtask

    task automatic tx_job(input string req, input logic [31:0] p, input logic [15:0] l,
                          input logic [1:0] opt, input logic [7:0] st);
        int n = 0;
        while (!tx_start_valid && n < 60) begin @(negedge clk); n++; end
        chk({req, " tx offer valid"}, 32'(tx_start_valid), 32'd1);
        chk({req, " tx ptr"}, tx_start_ptr, p);
        chk({req, " tx len"}, 32'(tx_start_len), 32'(l));
        chk({req, " tx pad/crc"}, 32'({tx_start_pad, tx_start_crc}), 32'(opt));
        tx_start_ready = 1'b1;
        @(negedge clk);
        tx_start_ready = 1'b0;
        chk("R10 tx valid drops", 32'(tx_start_valid), 32'd0);
        chk("R10 tx done ready", 32'(tx_done_ready), 32'd1);
        tx_done_valid = 1'b1; tx_done_stat = st;
        @(negedge clk);
        tx_done_valid = 1'b0;
    endtask

    task automatic rx_job(input string req, input logic [31:0] p, input logic [15:0] cap,
                          input logic [15:0] dl, input logic [7:0] st);
        int n = 0;
        while (!rx_start_valid && n < 60) begin @(negedge clk); n++; end
        chk({req, " rx offer valid"}, 32'(rx_start_valid), 32'd1);
        chk({req, " rx ptr"}, rx_start_ptr, p);
        chk({req, " rx len"}, 32'(rx_start_len), 32'(cap));
        rx_start_ready = 1'b1;
        @(negedge clk);
        rx_start_ready = 1'b0;
        chk("R10 rx done ready", 32'(rx_done_ready), 32'd1);
        rx_done_valid = 1'b1; rx_done_stat = st; rx_done_len = dl;
        @(negedge clk);
        rx_done_valid = 1'b0;
    endtask

    task automatic quiet(input string req, input int cyc);
        int seen = 0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            if (tx_start_valid) seen |= 1;
            if (rx_start_valid) seen |= 2;
        end
        chk(req, 32'(seen), 32'd0);
    endtask

    task automatic quiet_tx(input string req, input int cyc);
        int seen = 0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            if (tx_start_valid) seen = 1;
        end
        chk(req, 32'(seen), 32'd0);
    endtask

    task automatic quiet_rx(input string req, input int cyc);
        int seen = 0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            if (rx_start_valid) seen = 1;
        end
        chk(req, 32'(seen), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired before the test ended");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, s0, s1, s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 tx valid", 32'(tx_start_valid), 0);
        chk("R9 rx valid", 32'(rx_start_valid), 0);
        chk("R9 irqs", 32'({irq_rx, irq_tx}), 0);
        rd(5'h10, d); chk("R9 split reset", d, 32'd4);
        rd(sa(0), d); chk("R9 table zero", d, 0);

        // R1: full table sweep with ownership clear
        for (int w = 0; w < 16; w++)
            wr(5'(w), (32'hA5C3_0000 + 32'(w) * 32'h0001_0203) & ~32'h0000_8000);
        for (int w = 0; w < 16; w++) begin
            rd(5'(w), d);
            chk("R1 table word", d, (32'hA5C3_0000 + 32'(w) * 32'h0001_0203) & ~32'h0000_8000);
        end
        quiet("R3 no offer while nothing owned", 10);

        // R6: split of 3, soft reset
        wr(5'h10, 32'd3);
        wr(5'h11, 32'd1);
        rd(5'h10, d); chk("R6 split readback", d, 32'd3);

        // Transmit ring entries 0..2; entry 1 carries wrap
        s0 = mk(16'h0040, 1, 1, 0, 1, 0) | 32'h0000_0500;
        s1 = mk(16'h0022, 1, 0, 1, 0, 1);
        arm(0, 32'h1000_0000, s0);
        arm(1, 32'h1000_0600, s1);
        arm(2, 32'h1000_0C00, mk(16'h0010, 1, 0, 0, 0, 0));
        tx_job("R2", 32'h1000_0000, 16'h0040, 2'b10, 8'hA5);
        chk("R7 tx irq set", 32'(irq_tx), 1);
        rd(sa(0), d); chk("R4 tx writeback", d, {16'h0040, 1'b0, s0[14:8], 8'hA5});
        tx_job("R2", 32'h1000_0600, 16'h0022, 2'b01, 8'h3C);
        chk("R7 tx irq sticky", 32'(irq_tx), 1);
        rd(sa(1), d); chk("R4 tx writeback", d, {16'h0022, 1'b0, s1[14:8], 8'h3C});
        quiet_tx("R5 wrap back to 0, entry 2 not reached; R3 stall", 12);
        wr(5'h12, 32'd1);
        rd(5'h12, d); chk("R7 tx irq cleared", d, 0);

        // R3: re-arm the stalled entry
        arm(0, 32'h2000_0000, mk(16'h0008, 1, 0, 0, 0, 0));
        tx_job("R3", 32'h2000_0000, 16'h0008, 2'b00, 8'h11);
        chk("R7 no irq without request", 32'(irq_tx), 0);

        // R8: soft reset pulls transmit walker from entry 1 back to 0
        arm(0, 32'h3000_0000, mk(16'h000C, 1, 0, 0, 1, 1));
        quiet_tx("R3 walker stays on unowned entry 1", 6);
        wr(5'h11, 32'd1);
        tx_job("R8", 32'h3000_0000, 16'h000C, 2'b11, 8'h01);

        // Receive ring 3..7; entry 5 requests an interrupt
        for (int i = 3; i < 8; i++)
            arm(i, 32'h4000_0000 + 32'(i) * 32'h600, mk(16'h0600, 1, i == 5, 0, 0, 0));
        for (int i = 3; i < 8; i++) begin
            rx_job("R2", 32'h4000_0000 + 32'(i) * 32'h600, 16'h0600, 16'h0040 + 16'(i), 8'(i));
            s = mk(16'h0600, 1, i == 5, 0, 0, 0);
            rd(sa(i), d); chk("R4 rx writeback", d, {16'h0040 + 16'(i), 1'b0, s[14:8], 8'(i)});
            if (i == 4) chk("R7 rx irq still low", 32'(irq_rx), 0);
            if (i == 5) chk("R7 rx irq set", 32'(irq_rx), 1);
        end
        // R5: after the last ring entry the walker returns to 3, not 0
        arm(0, 32'hDEAD_0000, mk(16'h0004, 1, 0, 0, 0, 0));
        arm(3, 32'h5000_0000, mk(16'h0100, 1, 0, 0, 0, 0));
        rx_job("R5", 32'h5000_0000, 16'h0100, 16'h0020, 8'h77);

        // R6: new split of 6; rx starts at 6, tx at 0
        wr(5'h10, 32'd6);
        arm(4, 32'h7000_0000, mk(16'h0100, 1, 0, 0, 0, 0));
        arm(6, 32'h6000_0000, mk(16'h0200, 1, 0, 0, 0, 0));
        wr(5'h11, 32'd1);
        rx_job("R6", 32'h6000_0000, 16'h0200, 16'h0011, 8'h22);
        tx_job("R6", 32'hDEAD_0000, 16'h0004, 2'b00, 8'h33);

        // R6: clamp and empty receive ring
        wr(5'h10, 32'd15);
        rd(5'h10, d); chk("R6 split clamp", d, 32'd8);
        wr(5'h11, 32'd1);
        arm(7, 32'h8000_0000, mk(16'h0100, 1, 0, 0, 0, 0));
        quiet_rx("R6 empty receive ring never offers", 10);
        wr(5'h12, 32'd3);
        rd(5'h12, d); chk("R7 both irqs cleared", d, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule